// File: doc/BRIEF.md
# System Exception Pending Control Register

This block is one memory-mapped control and status word inside a processor interrupt controller. It holds the pending flags of three system exceptions: a non-maskable interrupt (NMI), a deferred service call that software raises on purpose, and a periodic timer tick. Software makes these exceptions pending by writing ones to set bits. The deferred call and the tick also have write-only clear bits. When the controller enters the handler of one of these exceptions, it pulses an entry strobe, and that strobe clears the matching flag. The three flags are also driven out as levels to the arbitration logic.

A read returns the three flags together with read-only views of live controller state: the active exception number, the highest-priority pending exception number, an any-interrupt-pending flag, a preempted-exceptions flag and a return-to-base flag. Only privileged accesses take effect. An access made without privilege gets an error response, reads as zero and changes nothing.

A small response state machine answers every access one cycle after it is presented. It has three states: `RSP_IDLE` (no response), `RSP_DONE` (a good response) and `RSP_FAULT` (an error response). From any state it moves to `RSP_IDLE` when there is no access, to `RSP_FAULT` on an unprivileged access, and to `RSP_DONE` on a privileged access.

Top module: `sysexc_pend_reg`

## Requirements
- R1: After reset, all three pending outputs are 0, `rsp_valid` and `rsp_err` are 0, and `rsp_rdata` is 0.
- R2: A privileged write with bit 31 = 1 makes the NMI pending. Writing 0 to bit 31 has no effect. A read returns the NMI flag in bit 31.
- R3: An entry strobe (`nmi_enter`, `defer_enter` or `tick_enter`) clears only its own exception's pending flag, on the next clock edge.
- R4: A privileged write with bit 28 = 1 makes the deferred call pending. A write with bit 27 = 1 clears it. Zeros in these bits have no effect. A read returns the flag in bit 28, and bit 27 reads 0.
- R5: A privileged write with bit 26 = 1 makes the tick pending. A write with bit 25 = 1 clears it. A read returns the flag in bit 26, and bit 25 reads 0.
- R6: If one write has both the set bit and the clear bit of the same exception at 1, that exception ends up not pending.
- R7: If a set write and the entry strobe of the same exception arrive in the same cycle, the exception ends up pending.
- R8: A privileged read returns bit 23 = `preempted`, bit 22 = `any_irq_pend`, bits 12 and up = `top_pend_num`, bit 11 = `base_return` and bits 0 and up = `act_num`. All other bits read 0.
- R9: An access with `bus_priv` = 0 gets `rsp_err` = 1 and `rsp_rdata` = 0, and it leaves all pending flags unchanged.
- R10: Every access gets exactly one response with `rsp_valid` = 1 in the next cycle. The read data is taken from the state in the cycle the access was presented. A cycle with no access gives `rsp_valid` = 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | An access is presented this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | The access is privileged |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_err | output | 1 | Error response (unprivileged access) |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| nmi_enter | input | 1 | Pulses when the NMI handler is entered |
| defer_enter | input | 1 | Pulses when the deferred-call handler is entered |
| tick_enter | input | 1 | Pulses when the tick handler is entered |
| act_num | input | ACT_W (9) | Active exception number |
| top_pend_num | input | PEND_W (7) | Highest-priority pending exception number |
| any_irq_pend | input | 1 | Some interrupt is pending |
| preempted | input | 1 | Preempted active exceptions exist |
| base_return | input | 1 | Return to base level indicator |
| nmi_pend | output | 1 | NMI pending flag |
| defer_pend | output | 1 | Deferred-call pending flag |
| tick_pend | output | 1 | Tick pending flag |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions. These are a set bit and its clear bit in one write, and a software set that lands in the same cycle as the hardware entry strobe. Both are easy to miss, because the flag looks the same before and after.

The stimulus table drives these collisions on purpose. It starts each one from a known flag state and checks the flag outputs right after the edge. Dedicated rows also put unprivileged writes of clear bits onto flags that are set, to show those writes have no effect.

// File: rtl/sysexc_pkg.sv
package sysexc_pkg;

    // Response state machine states.
    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_DONE  = 2'd1,
        RSP_FAULT = 2'd2
    } rsp_state_e;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned NUM_EXC = 3;

    // Index of each exception in the pending vector.
    localparam int unsigned IDX_TICK  = 0;
    localparam int unsigned IDX_DEFER = 1;
    localparam int unsigned IDX_NMI   = 2;

    // Bit positions that software decodes.
    localparam int unsigned NMI_SET_BIT   = 31;
    localparam int unsigned DEFER_SET_BIT = 28;
    localparam int unsigned DEFER_CLR_BIT = 27;
    localparam int unsigned TICK_SET_BIT  = 26;
    localparam int unsigned TICK_CLR_BIT  = 25;
    localparam int unsigned PREEMPT_BIT   = 23;
    localparam int unsigned ANYPEND_BIT   = 22;
    localparam int unsigned PENDNUM_LSB   = 12;
    localparam int unsigned BASERET_BIT   = 11;

endpackage

// File: rtl/sysexc_pend_cell.sv
module sysexc_pend_cell #(
    parameter bit HAS_CLR = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic enter_i,
    output logic pend_o
);

    logic clr_eff;
    assign clr_eff = HAS_CLR ? clr_i : 1'b0;

    // Priority: a software clear beats a software set.
    // A software set beats the handler-entry strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
        end else if (set_i && !clr_eff) begin
            pend_o <= 1'b1;
        end else if (clr_eff || enter_i) begin
            pend_o <= 1'b0;
        end
    end

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_eff) |=> pend_o);

    assert_enter_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_i && !set_i) |=> !pend_o);

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_eff && !enter_i) |=> $stable(pend_o));

    generate
        if (HAS_CLR) begin : g_clr_chk
            assert_clear_beats_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
                clr_i |=> !pend_o);
        end
    endgenerate

endmodule

// File: rtl/sysexc_bus_fsm.sv
module sysexc_bus_fsm
    import sysexc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_priv,
    input  logic [WORD_W-1:0] rd_word,
    output logic              wr_ok,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [WORD_W-1:0] rsp_rdata
);

    rsp_state_e state_q, state_d;
    logic [WORD_W-1:0] rdata_q;

    // A write only takes effect when it is privileged.
    assign wr_ok = acc_valid && acc_write && acc_priv;

    // Next state: the same three transitions apply from every state.
    always_comb begin
        state_d = RSP_IDLE;
        unique case (state_q)
            RSP_IDLE, RSP_DONE, RSP_FAULT: begin
                if (!acc_valid)     state_d = RSP_IDLE;
                else if (!acc_priv) state_d = RSP_FAULT;
                else                state_d = RSP_DONE;
            end
            default: state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= (acc_valid && acc_priv && !acc_write) ? rd_word : '0;
        end
    end

    // Outputs are decoded from the state register.
    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            RSP_IDLE: begin
                rsp_valid = 1'b0;
            end
            RSP_DONE: begin
                rsp_valid = 1'b1;
                rsp_rdata = rdata_q;
            end
            RSP_FAULT: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default: rsp_valid = 1'b0;
        endcase
    end

    assert_access_answered_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);

    assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);

    assert_unpriv_faults_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_priv) |=> (rsp_err && rsp_rdata == '0));

    assert_write_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write) |=> (rsp_rdata == '0));

endmodule

// File: rtl/sysexc_read_pack.sv
module sysexc_read_pack
    import sysexc_pkg::*;
#(
    parameter int unsigned ACT_W  = 9,
    parameter int unsigned PEND_W = 7
) (
    input  logic [NUM_EXC-1:0] pend_vec,
    input  logic [ACT_W-1:0]   act_num,
    input  logic [PEND_W-1:0]  top_pend_num,
    input  logic               any_irq_pend,
    input  logic               preempted,
    input  logic               base_return,
    output logic [WORD_W-1:0]  word_o
);

    // The field widths must fit below their neighbours.
    localparam bit ACT_FITS  = (ACT_W <= BASERET_BIT);
    localparam bit PEND_FITS = (PENDNUM_LSB + PEND_W <= ANYPEND_BIT);

    generate
        if (!ACT_FITS || !PEND_FITS) begin : g_bad_widths
            initial $error("sysexc_read_pack: status field widths overlap");
        end
    endgenerate

    // Reserved bits and the write-only clear bits read 0.
    always_comb begin
        word_o = '0;
        word_o[NMI_SET_BIT]   = pend_vec[IDX_NMI];
        word_o[DEFER_SET_BIT] = pend_vec[IDX_DEFER];
        word_o[TICK_SET_BIT]  = pend_vec[IDX_TICK];
        word_o[PREEMPT_BIT]   = preempted;
        word_o[ANYPEND_BIT]   = any_irq_pend;
        word_o[PENDNUM_LSB +: PEND_W] = top_pend_num;
        word_o[BASERET_BIT]   = base_return;
        word_o[0 +: ACT_W]    = act_num;
    end

    always_comb begin
        assert_clr_bits_read_zero_R8: assert (word_o[DEFER_CLR_BIT] == 1'b0 && word_o[TICK_CLR_BIT] == 1'b0);
    end

endmodule

// File: rtl/sysexc_pend_reg.sv
module sysexc_pend_reg
    import sysexc_pkg::*;
#(
    parameter int unsigned ACT_W  = 9,
    parameter int unsigned PEND_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_priv,
    input  logic [31:0]       bus_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    input  logic              nmi_enter,
    input  logic              defer_enter,
    input  logic              tick_enter,
    input  logic [ACT_W-1:0]  act_num,
    input  logic [PEND_W-1:0] top_pend_num,
    input  logic              any_irq_pend,
    input  logic              preempted,
    input  logic              base_return,
    output logic              nmi_pend,
    output logic              defer_pend,
    output logic              tick_pend
);

    logic                wr_ok;
    logic [NUM_EXC-1:0]  set_vec, clr_vec, enter_vec, pend_vec;
    logic [WORD_W-1:0]   rd_word;
    logic                unused_wdata_bits;

    // Decode the write into per-exception set and clear requests.
    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        set_vec[IDX_NMI]   = wr_ok && bus_wdata[NMI_SET_BIT];
        set_vec[IDX_DEFER] = wr_ok && bus_wdata[DEFER_SET_BIT];
        clr_vec[IDX_DEFER] = wr_ok && bus_wdata[DEFER_CLR_BIT];
        set_vec[IDX_TICK]  = wr_ok && bus_wdata[TICK_SET_BIT];
        clr_vec[IDX_TICK]  = wr_ok && bus_wdata[TICK_CLR_BIT];
    end

    assign unused_wdata_bits = ^{bus_wdata[30:29], bus_wdata[24:0]};

    assign enter_vec[IDX_NMI]   = nmi_enter;
    assign enter_vec[IDX_DEFER] = defer_enter;
    assign enter_vec[IDX_TICK]  = tick_enter;

    // One pending cell per exception. The NMI cell has no clear bit.
    generate
        for (genvar i = 0; i < NUM_EXC; i++) begin : g_cell
            sysexc_pend_cell #(
                .HAS_CLR (i != IDX_NMI)
            ) u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_i   (set_vec[i]),
                .clr_i   (clr_vec[i]),
                .enter_i (enter_vec[i]),
                .pend_o  (pend_vec[i])
            );
        end
    endgenerate

    sysexc_read_pack #(
        .ACT_W  (ACT_W),
        .PEND_W (PEND_W)
    ) u_pack (
        .pend_vec     (pend_vec),
        .act_num      (act_num),
        .top_pend_num (top_pend_num),
        .any_irq_pend (any_irq_pend),
        .preempted    (preempted),
        .base_return  (base_return),
        .word_o       (rd_word)
    );

    sysexc_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (bus_valid),
        .acc_write (bus_write),
        .acc_priv  (bus_priv),
        .rd_word   (rd_word),
        .wr_ok     (wr_ok),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

    assign nmi_pend   = pend_vec[IDX_NMI];
    assign defer_pend = pend_vec[IDX_DEFER];
    assign tick_pend  = pend_vec[IDX_TICK];

    assert_unpriv_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_priv && !nmi_enter && !defer_enter && !tick_enter)
        |=> $stable({nmi_pend, defer_pend, tick_pend}));

    assert_nmi_only_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_pend) |-> $past(bus_valid && bus_write && bus_priv && bus_wdata[NMI_SET_BIT]));

endmodule

// File: tb/sim_sysexc_pend_reg.sv
`timescale 1ns/1ps
module sim_sysexc_pend_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_priv = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        nmi_enter = 1'b0, defer_enter = 1'b0, tick_enter = 1'b0;
    logic [8:0]  act_num = '0;
    logic [6:0]  top_pend_num = '0;
    logic        any_irq_pend = 1'b0, preempted = 1'b0, base_return = 1'b0;
    logic        nmi_pend, defer_pend, tick_pend;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sysexc_pend_reg u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_priv(bus_priv), .bus_wdata(bus_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .nmi_enter(nmi_enter), .defer_enter(defer_enter), .tick_enter(tick_enter),
        .act_num(act_num), .top_pend_num(top_pend_num), .any_irq_pend(any_irq_pend),
        .preempted(preempted), .base_return(base_return),
        .nmi_pend(nmi_pend), .defer_pend(defer_pend), .tick_pend(tick_pend)
    );

    // Row layout: [40] valid, [39] write, [38] priv, [37:35] entry strobes {nmi,defer,tick},
    // [34:32] expected flags {nmi,defer,tick}, [31:0] write data.
    localparam int NV = 16;
    localparam logic [40:0] VECS [NV] = '{
        {3'b111, 3'b000, 3'b100, 32'h8000_0000}, // R2 set NMI
        {3'b111, 3'b000, 3'b100, 32'h0000_0000}, // R2 zero write has no effect
        {3'b000, 3'b100, 3'b000, 32'h0000_0000}, // R3 NMI entry clears
        {3'b111, 3'b000, 3'b010, 32'h1000_0000}, // R4 set deferred
        {3'b111, 3'b000, 3'b011, 32'h0400_0000}, // R5 set tick
        {3'b111, 3'b000, 3'b001, 32'h0800_0000}, // R4 clear deferred
        {3'b111, 3'b000, 3'b000, 32'h0200_0000}, // R5 clear tick
        {3'b111, 3'b000, 3'b000, 32'h1800_0000}, // R6 deferred set+clear
        {3'b111, 3'b000, 3'b001, 32'h0400_0000}, // R5 set tick again
        {3'b111, 3'b000, 3'b000, 32'h0600_0000}, // R6 tick set+clear
        {3'b111, 3'b111, 3'b111, 32'h9400_0000}, // R7 set with entry strobes
        {3'b110, 3'b000, 3'b111, 32'h0A00_0000}, // R9 unprivileged clear ignored
        {3'b000, 3'b010, 3'b101, 32'h0000_0000}, // R3 deferred entry clears only it
        {3'b000, 3'b001, 3'b100, 32'h0000_0000}, // R3 tick entry clears only it
        {3'b111, 3'b100, 3'b100, 32'h8000_0000}, // R7 NMI set with NMI entry
        {3'b111, 3'b000, 3'b100, 32'h0A00_0000}  // R6 clear bits with nothing to clear
    };
    localparam int REQ [NV] = '{2, 2, 3, 4, 5, 4, 5, 6, 5, 6, 7, 9, 3, 3, 7, 6};

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] exp_word;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "flags", {29'd0, nmi_pend, defer_pend, tick_pend}, 32'd0);
        check("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R1", "rsp_err", {31'd0, rsp_err}, 32'd0);
        check("R1", "rsp_rdata", rsp_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            bus_valid   = VECS[i][40];
            bus_write   = VECS[i][39];
            bus_priv    = VECS[i][38];
            nmi_enter   = VECS[i][37];
            defer_enter = VECS[i][36];
            tick_enter  = VECS[i][35];
            bus_wdata   = VECS[i][31:0];
            @(posedge clk);
            @(negedge clk);
            bus_valid = 1'b0; nmi_enter = 1'b0; defer_enter = 1'b0; tick_enter = 1'b0;
            check($sformatf("R%0d", REQ[i]), $sformatf("row %0d flags", i),
                  {29'd0, nmi_pend, defer_pend, tick_pend}, {29'd0, VECS[i][34:32]});
            check("R10", $sformatf("row %0d rsp_valid", i), {31'd0, rsp_valid}, {31'd0, VECS[i][40]});
            check("R9", $sformatf("row %0d rsp_err", i), {31'd0, rsp_err},
                  {31'd0, VECS[i][40] & ~VECS[i][38]});
        end

        // Flags now {nmi=1,defer=0,tick=0}; set the tick too.
        bus_valid = 1'b1; bus_write = 1'b1; bus_priv = 1'b1; bus_wdata = 32'h0400_0000;
        @(posedge clk); @(negedge clk);
        // R8 privileged read with known status inputs
        act_num = 9'h1A5; top_pend_num = 7'h55; any_irq_pend = 1'b1; preempted = 1'b1; base_return = 1'b1;
        bus_valid = 1'b1; bus_write = 1'b0; bus_priv = 1'b1; bus_wdata = 32'hFFFF_FFFF;
        exp_word = (32'd1 << 31) | (32'd1 << 26) | (32'd1 << 23) | (32'd1 << 22)
                 | (32'h55 << 12) | (32'd1 << 11) | 32'h1A5;
        @(posedge clk); @(negedge clk);
        check("R8", "status read", rsp_rdata, exp_word);
        check("R10", "read rsp_valid", {31'd0, rsp_valid}, 32'd1);
        check("R2", "NMI readback bit 31", {31'd0, rsp_rdata[31]}, 32'd1);

        // R10 read data comes from the accept cycle; status changes after the access.
        act_num = 9'h003; top_pend_num = 7'h00; any_irq_pend = 1'b0; preempted = 1'b0; base_return = 1'b0;
        bus_valid = 1'b1; bus_priv = 1'b1; bus_write = 1'b0;
        @(posedge clk); @(negedge clk);
        act_num = 9'h0FF;
        bus_valid = 1'b0;
        check("R10", "snapshot read", rsp_rdata, (32'd1 << 31) | (32'd1 << 26) | 32'h003);
        @(posedge clk); @(negedge clk);
        check("R10", "idle gives no response", {31'd0, rsp_valid}, 32'd0);

        // R4 / R5: set the deferred call, read back bit 28; clear bits read 0.
        bus_valid = 1'b1; bus_write = 1'b1; bus_priv = 1'b1; bus_wdata = 32'h1000_0000;
        @(posedge clk); @(negedge clk);
        bus_write = 1'b0; act_num = 9'h000;
        @(posedge clk); @(negedge clk);
        check("R4", "deferred readback", rsp_rdata, (32'd1 << 31) | (32'd1 << 28) | (32'd1 << 26));
        check("R5", "clear bits read 0", {30'd0, rsp_rdata[27], rsp_rdata[25]}, 32'd0);

        // R9 unprivileged read: error, zero data, flags unchanged.
        bus_priv = 1'b0;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0;
        check("R9", "unpriv read data", rsp_rdata, 32'd0);
        check("R9", "unpriv read err", {31'd0, rsp_err}, 32'd1);
        check("R9", "unpriv flags", {29'd0, nmi_pend, defer_pend, tick_pend}, 32'd7);

        // R1 reset in the middle of a run clears every flag.
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "re-reset flags", {29'd0, nmi_pend, defer_pend, tick_pend}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule